// File: doc/BRIEF.md
# Serial DMA Request Encoder

This block lets a peripheral ask a bus host for DMA service over one dedicated active-low request wire. The wire runs on the bus clock. For each of eight channels the peripheral can raise a request or abandon one. The block then sends a short serial frame on the wire. The frame carries the channel number and a flag that says whether the request is being raised or withdrawn.

The block also watches the SYNC codes that the peripheral returns during DMA cycles. From them it tracks which channels still have a request standing with the host. A channel whose request is still standing is never encoded again. A channel whose transfer completed with SYNC 0000 must wait a hold-off time before it can be requested again. When several channels are waiting, the frames go out back to back with one idle clock between them, lowest channel first.

Top module: `dreq_encoder`

## Requirements
- R1: Out of reset the request line is high, no channel is pending, and no hold-off is running.
- R2: A frame is five clocks long. It starts with the line low for exactly one clock. Then come the three channel bits, most significant first, and then the ACT bit. The line is high for at least one clock after the ACT bit, before any further start bit.
- R3: A one-clock pulse on `req_set_i[c]` for a channel with no pending request produces a frame for channel c with ACT=1. `pend_o[c]` goes high from the clock that drives the start bit.
- R4: Requests for different channels do not wait for earlier ones to be acknowledged. When frames are queued, each start bit follows the previous start bit by exactly six clocks.
- R5: When several channels are waiting to be encoded, the lowest-numbered channel is sent first.
- R6: A `req_set_i[c]` pulse while channel c is pending is ignored. It produces no frame, either then or after the request is later abandoned.
- R7: A SYNC of 0000 (`sync_vld_i` with `sync_code_i`=4'b0000) for channel c clears its pending flag. The next start bit for c comes no earlier than the tenth clock after the clock on which the SYNC was presented. When the line is idle and a request is already waiting, it comes exactly then.
- R8: A SYNC of 1001 for channel c leaves `pend_o[c]` high and produces no frame.
- R9: A `req_drop_i[c]` pulse for a pending channel produces a frame for channel c with ACT=0, and it clears `pend_o[c]`.
- R10: A `req_drop_i[c]` pulse for a channel that is not pending produces no frame. It also cancels any request for c that is waiting and has not yet been framed.
- R11: When a SYNC of 0000 and a drop for the same pending channel arrive on the same clock, the SYNC wins. No abandon frame is sent, and the channel ends up not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | NUM_CH | One-clock pulse per channel: raise a request |
| req_drop_i | input | NUM_CH | One-clock pulse per channel: abandon a request |
| sync_vld_i | input | 1 | A SYNC code was returned this clock |
| sync_ch_i | input | CH_W | Channel the SYNC code belongs to |
| sync_code_i | input | 4 | SYNC code value |
| dreq_n_o | output | 1 | Serial active-low request line |
| pend_o | output | NUM_CH | Per-channel request-standing flags |

## Verification
The two functions that can meet in one clock are the completion path (SYNC 0000) and the abandon path (drop) for the same channel. They are provoked by driving both on one clock for a channel the bench has seen framed as pending. The case is judged at the ports: the line must carry no ACT=0 frame for that channel, and `pend_o` for it must read low afterwards. A random phase also overlaps new requests with SYNC returns on other channels. Every decoded frame is checked against the bench's own pending set and hold-off timestamps.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam logic [3:0] SYNC_DONE = 4'b0000;
  localparam logic [3:0] SYNC_KEEP = 4'b1001;
endpackage

// File: rtl/dreq_chan.sv
module dreq_chan #(
  parameter int HOLDOFF = 8,
  localparam int CNT_W = $clog2(HOLDOFF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic drop_i,
  input  logic done_i,
  input  logic grant_i,
  output logic offer_act_o,
  output logic offer_abn_o,
  output logic pend_o
);
  logic [CNT_W-1:0] hold_q;
  logic pend_q, abn_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      abn_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (done_i)             hold_q <= CNT_W'(HOLDOFF);
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;

      if (done_i)                pend_q <= 1'b0;
      else if (grant_i && abn_q) pend_q <= 1'b0;
      else if (grant_i)          pend_q <= 1'b1;

      // a drop racing an assert grant becomes an abandon of that request
      if (done_i)                           abn_q <= 1'b0;
      else if (grant_i && abn_q)            abn_q <= 1'b0;
      else if (drop_i && (pend_q || grant_i)) abn_q <= 1'b1;

      if (drop_i)                            act_q <= 1'b0;
      else if (grant_i && !abn_q)            act_q <= 1'b0;
      else if (set_i && !pend_q && !grant_i) act_q <= 1'b1;
    end
  end

  assign offer_abn_o = abn_q;
  assign offer_act_o = act_q && !pend_q && (hold_q == '0);
  assign pend_o      = pend_q;
endmodule

// File: rtl/dreq_pick.sv
module dreq_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] offer_act_i,
  input  logic [NUM_CH-1:0] offer_abn_i,
  output logic              vld_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              act_o
);
  always_comb begin
    vld_o = 1'b0;
    ch_o  = '0;
    act_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (offer_act_i[i] || offer_abn_i[i]) begin
        vld_o = 1'b1;
        ch_o  = CH_W'(i);
        act_o = !offer_abn_i[i];
      end
    end
  end
endmodule

// File: rtl/dreq_ser.sv
module dreq_ser #(
  parameter int CH_W = 3,
  localparam int SH_W = CH_W + 2,
  localparam int N_W  = $clog2(SH_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            act_i,
  output logic            ready_o,
  output logic            line_o
);
  logic [SH_W-1:0] sh_q;
  logic [N_W-1:0]  left_q;
  logic            line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      line_q <= 1'b1;
    end else if (load_i) begin
      line_q <= 1'b0;
      sh_q   <= {ch_i, act_i, 1'b1};  // trailing 1 forms the idle gap
      left_q <= N_W'(SH_W);
    end else if (left_q != '0) begin
      line_q <= sh_q[SH_W-1];
      sh_q   <= {sh_q[SH_W-2:0], 1'b1};
      left_q <= left_q - 1'b1;
    end
  end

  assign ready_o = (left_q == '0);
  assign line_o  = line_q;
endmodule

// File: rtl/dreq_encoder.sv
module dreq_encoder #(
  parameter int NUM_CH  = 8,
  parameter int HOLDOFF = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_set_i,
  input  logic [NUM_CH-1:0] req_drop_i,
  input  logic              sync_vld_i,
  input  logic [CH_W-1:0]   sync_ch_i,
  input  logic [3:0]        sync_code_i,
  output logic              dreq_n_o,
  output logic [NUM_CH-1:0] pend_o
);
  import dreq_pkg::*;

  logic [NUM_CH-1:0] done_v, offer_act, offer_abn, chan_gnt;
  logic              pick_vld, pick_act, ser_ready, frame_load;
  logic [CH_W-1:0]   pick_ch;

  assign frame_load = pick_vld && ser_ready;

  // SYNC_KEEP needs no action: the standing request is left untouched
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    assign done_v[gi]   = sync_vld_i && (sync_ch_i == CH_W'(gi)) && (sync_code_i == SYNC_DONE);
    assign chan_gnt[gi] = frame_load && (pick_ch == CH_W'(gi));

    dreq_chan #(.HOLDOFF(HOLDOFF)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (req_set_i[gi]),
      .drop_i     (req_drop_i[gi]),
      .done_i     (done_v[gi]),
      .grant_i    (chan_gnt[gi]),
      .offer_act_o(offer_act[gi]),
      .offer_abn_o(offer_abn[gi]),
      .pend_o     (pend_o[gi])
    );
  end

  dreq_pick #(.NUM_CH(NUM_CH)) u_pick (
    .offer_act_i(offer_act),
    .offer_abn_i(offer_abn),
    .vld_o      (pick_vld),
    .ch_o       (pick_ch),
    .act_o      (pick_act)
  );

  dreq_ser #(.CH_W(CH_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_load),
    .ch_i   (pick_ch),
    .act_i  (pick_act),
    .ready_o(ser_ready),
    .line_o (dreq_n_o)
  );
endmodule

// File: rtl/dreq_encoder_chk.sv
module dreq_encoder_chk #(
  parameter int NUM_CH  = 8,
  parameter int HOLDOFF = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(HOLDOFF + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dreq_n_o,
  input logic [NUM_CH-1:0] pend_o,
  input logic              sync_vld_i,
  input logic [CH_W-1:0]   sync_ch_i,
  input logic [3:0]        sync_code_i,
  input logic              frame_load,
  input logic [CH_W-1:0]   pick_ch,
  input logic              pick_act
);
  logic [CNT_W-1:0] since_q [NUM_CH];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_since
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) since_q[gi] <= CNT_W'(HOLDOFF);
      else if (sync_vld_i && sync_ch_i == CH_W'(gi) && sync_code_i == 4'b0000) since_q[gi] <= '0;
      else if (since_q[gi] != CNT_W'(HOLDOFF)) since_q[gi] <= since_q[gi] + 1'b1;
    end
  end

  AST_IDLE_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_load |-> dreq_n_o); // R2
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_load |=> !dreq_n_o); // R2
  AST_ACT_ONLY_IDLE_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_load && pick_act) |-> !pend_o[pick_ch]); // R6
  AST_ABANDON_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_load && !pick_act) |-> pend_o[pick_ch]); // R9
  AST_HOLDOFF_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_load && pick_act) |-> (since_q[pick_ch] == CNT_W'(HOLDOFF))); // R7
  AST_KEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_vld_i && sync_code_i == 4'b1001 && pend_o[sync_ch_i]
     && !(frame_load && !pick_act && pick_ch == sync_ch_i)) |=> pend_o[$past(sync_ch_i)]); // R8
  AST_PEND_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_load && pick_act && !(sync_vld_i && sync_ch_i == pick_ch)) |=> pend_o[$past(pick_ch)]); // R3
endmodule

bind dreq_encoder dreq_encoder_chk #(.NUM_CH(NUM_CH), .HOLDOFF(HOLDOFF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dreq_n_o   (dreq_n_o),
  .pend_o     (pend_o),
  .sync_vld_i (sync_vld_i),
  .sync_ch_i  (sync_ch_i),
  .sync_code_i(sync_code_i),
  .frame_load (frame_load),
  .pick_ch    (pick_ch),
  .pick_act   (pick_act)
);

// File: tb/tb_dreq_encoder.sv
`timescale 1ns/1ps
module tb_dreq_encoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_set = '0, req_drop = '0;
  logic       sync_vld = 1'b0;
  logic [2:0] sync_ch = '0;
  logic [3:0] sync_code = '0;
  logic       dreq_n;
  logic [7:0] pend;

  int n_chk = 0, n_err = 0, cyc = 0;
  int q_ch[$], q_act[$], q_start[$];
  int last_done[8];
  bit bp[8];
  bit rnd_mode = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dreq_encoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_set_i(req_set), .req_drop_i(req_drop),
    .sync_vld_i(sync_vld), .sync_ch_i(sync_ch), .sync_code_i(sync_code),
    .dreq_n_o(dreq_n), .pend_o(pend)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pend_vec();
    int v = 0;
    for (int i = 0; i < 8; i++) if (bp[i]) v |= (1 << i);
    return v;
  endfunction

  // frame decoder on the line
  int mst = 0, m_start = 0;
  logic [3:0] m_bits;
  always @(negedge clk) begin
    if (!rst_ni) mst = 0;
    else case (mst)
      0: if (!dreq_n) begin m_start = cyc; mst = 1; end
      1, 2, 3, 4: begin
        m_bits = {m_bits[2:0], dreq_n};
        if (mst == 4) begin
          if (rnd_mode) rnd_judge(int'(m_bits[3:1]), int'(m_bits[0]), m_start);
          else begin q_ch.push_back(int'(m_bits[3:1])); q_act.push_back(int'(m_bits[0])); q_start.push_back(m_start); end
        end
        mst = mst + 1;
      end
      default: begin
        chk(dreq_n == 1'b1, "R2", "idle clock after ACT", int'(dreq_n), 1);
        mst = 0;
      end
    endcase
  end

  task automatic rnd_judge(input int ch, input int act, input int st);
    if (act == 1) begin
      chk(!bp[ch], "R6", "ACT=1 frame for channel not yet pending", int'(bp[ch]), 0);
      chk(st - last_done[ch] >= 10, "R7", "hold-off before re-request", st - last_done[ch], 10);
      bp[ch] = 1'b1;
    end else begin
      chk(1'b0, "R9", "unexpected ACT=0 frame without drop", act, 1);
    end
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] d, input logic sv, input int ch, input logic [3:0] code);
    @(negedge clk);
    req_set = s; req_drop = d; sync_vld = sv; sync_ch = 3'(ch); sync_code = code;
    if (sv && code == 4'b0000) begin last_done[ch] = cyc; bp[ch] = 1'b0; end
    @(negedge clk);
    req_set = '0; req_drop = '0; sync_vld = 1'b0;
  endtask

  task automatic get_frame(input string req, input int ech, input int eact, output int st);
    int n = 0;
    while (q_ch.size() == 0 && n < 80) begin @(negedge clk); n++; end
    if (q_ch.size() == 0) begin
      chk(1'b0, req, "frame missing for channel", -1, ech);
      st = 0;
    end else begin
      int c = q_ch.pop_front(), a = q_act.pop_front();
      st = q_start.pop_front();
      chk(c == ech, req, "frame channel", c, ech);
      chk(a == eact, req, "frame ACT bit", a, eact);
    end
  endtask

  task automatic expect_quiet(input string req, input int ncyc);
    repeat (ncyc) @(negedge clk);
    chk(q_ch.size() == 0 && mst == 0, req, "frames on a quiet line", q_ch.size(), 0);
    q_ch.delete(); q_act.delete(); q_start.delete();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    report();
  end

  initial begin
    int s0, s1, s2, sd;
    void'($urandom(32'd20251));
    for (int i = 0; i < 8; i++) begin last_done[i] = -100; bp[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(dreq_n == 1'b1, "R1", "line during reset", int'(dreq_n), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(dreq_n == 1'b1 && pend == 8'h00, "R1", "line/pending after reset", int'(pend), 0);

    // R3: single request
    pulse(8'h20, 8'h00, 1'b0, 0, 4'h0);
    get_frame("R3", 5, 1, s0);
    chk(pend == 8'h20, "R3", "pending after assert frame", int'(pend), 32'h20);

    // R4 R5: three at once, lowest first, 6-clock spacing
    pulse(8'hC4, 8'h00, 1'b0, 0, 4'h0);
    get_frame("R5", 2, 1, s0);
    get_frame("R5", 6, 1, s1);
    get_frame("R5", 7, 1, s2);
    chk(s1 - s0 == 6, "R4", "start spacing 2->6", s1 - s0, 6);
    chk(s2 - s1 == 6, "R4", "start spacing 6->7", s2 - s1, 6);

    // R6: re-request while pending
    pulse(8'h20, 8'h00, 1'b0, 0, 4'h0);
    expect_quiet("R6", 30);
    // R8: keep code
    pulse(8'h00, 8'h00, 1'b1, 5, 4'b1001);
    expect_quiet("R8", 30);
    chk(pend[5] == 1'b1, "R8", "pending after SYNC 1001", int'(pend[5]), 1);

    // R9: abandon; ignored set must not resurface (R6)
    pulse(8'h00, 8'h20, 1'b0, 0, 4'h0);
    get_frame("R9", 5, 0, s0);
    chk(pend[5] == 1'b0, "R9", "pending after abandon", int'(pend[5]), 0);
    expect_quiet("R6", 30);

    // R10: drop for idle channel, and cancel of a queued request
    pulse(8'h00, 8'h08, 1'b0, 0, 4'h0);
    expect_quiet("R10", 20);
    pulse(8'h03, 8'h00, 1'b0, 0, 4'h0);
    pulse(8'h00, 8'h02, 1'b0, 0, 4'h0);
    get_frame("R10", 0, 1, s0);
    expect_quiet("R10", 30);
    chk(pend[1] == 1'b0, "R10", "cancelled channel pending", int'(pend[1]), 0);

    // R7: completion then immediate re-request
    pulse(8'h00, 8'h00, 1'b1, 2, 4'b0000);
    sd = last_done[2];
    pulse(8'h04, 8'h00, 1'b0, 0, 4'h0);
    get_frame("R7", 2, 1, s0);
    chk(s0 - sd == 10, "R7", "start bit delay after SYNC 0000", s0 - sd, 10);

    // R11: completion and drop collide
    pulse(8'h00, 8'h40, 1'b1, 6, 4'b0000);
    expect_quiet("R11", 30);
    chk(pend[6] == 1'b0, "R11", "pending after collision", int'(pend[6]), 0);

    // clear remaining standing requests (0, 2, 7)
    pulse(8'h00, 8'h00, 1'b1, 0, 4'b0000);
    pulse(8'h00, 8'h00, 1'b1, 2, 4'b0000);
    pulse(8'h00, 8'h00, 1'b1, 7, 4'b0000);
    repeat (5) @(negedge clk);
    chk(pend == 8'h00, "R7", "all cleared by SYNC 0000", int'(pend), 0);
    for (int i = 0; i < 8; i++) bp[i] = 1'b0;

    // random phase: requests overlapping completions and keeps
    repeat (20) @(negedge clk);
    rnd_mode = 1'b1;
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) pulse(8'(1 << $urandom_range(0, 7)) | 8'(1 << $urandom_range(0, 7)), 8'h00, 1'b0, 0, 4'h0);
      else if (r < 7) begin
        int c = $urandom_range(0, 7);
        if (bp[c]) pulse(8'h00, 8'h00, 1'b1, c, ($urandom_range(0, 2) == 0) ? 4'b1001 : 4'b0000);
        else @(negedge clk);
      end else @(negedge clk);
    end
    repeat (120) @(negedge clk);
    chk(int'(pend) == pend_vec(), "R3", "pending set versus decoded frames", int'(pend), pend_vec());
    for (int c = 0; c < 8; c++) if (bp[c]) pulse(8'h00, 8'h00, 1'b1, c, 4'b0000);
    repeat (40) @(negedge clk);
    chk(pend == 8'h00, "R7", "pending after final completions", int'(pend), 0);
    chk(dreq_n == 1'b1, "R1", "line idle at end", int'(dreq_n), 1);
    report();
  end
endmodule